// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Every pin carries its own four-bit sense code that picks one of five detection conditions: rising edge, falling edge, both edges, high level or low level. Any pin whose condition is met while its detection is switched on raises a pending flag. Software reads the flags raw or filtered through a separate interrupt mask, and clears them by writing ones to an acknowledge register.

Two interrupt lines leave the block. One covers the lower half of the pins and the other covers the upper half, so that the two groups can be routed to different handlers. Everything is reached through a simple word-addressed register bus with single-cycle write strobes and registered read data. The pins are expected to arrive already synchronised to the block clock.

To reprogram a pin safely, software first switches off its detection, then rewrites its sense field, acknowledges it, and finally switches detection back on. Within that sequence a change of sense code never invents an event.

Top module: `pin_sense_irq`

## Requirements
- R1: After a synchronous reset, every register reads zero (detection enables, interrupt mask, pending flags, status and all sense words), and both interrupt outputs are low.
- R2: Pin n's sense code sits in the word at address 8 + n/8, in bits 4*(n mod 8)+3 down to 4*(n mod 8). A sense word reads back exactly as it was written.
- R3: A sense code with low three bits 0 (codes 0 and 8) sets the pin's pending flag on a 0-to-1 transition only. Bit 3 of the code (the asynchronous flag) does not change detection.
- R4: Codes 1 and 9 set the pending flag on a 1-to-0 transition only.
- R5: Codes 2 and 10 hold the pending flag set for as long as the pin is high. An acknowledge written while the pin is high leaves the flag set. After the pin falls, an acknowledge clears it.
- R6: Codes 3 and 11 hold the pending flag set for as long as the pin is low.
- R7: Codes 4 and 12 set the pending flag on every transition of the pin in either direction.
- R8: Codes 5, 6, 7, 13, 14 and 15 never set the pending flag.
- R9: The detection-enable word (address 0) is plain read/write. A pin whose bit is 0 never sets its pending flag, and a pin level that was already present when detection was switched on is not taken as an edge.
- R10: Writing the acknowledge word (address 5) clears the pending flag of each pin whose bit is written as 1. Bits written as 0 have no effect. Address 5 reads as zero.
- R11: Writing 1s to address 1 sets mask bits and writing 1s to address 2 clears them; both addresses read back the mask. The raw pending word (address 3) shows every flag whatever the mask, and the status word (address 4) reads raw AND mask.
- R12: One clock after the status word changes, the low interrupt output equals the OR of status bits for the lower half of the pins, and the high interrupt output equals the OR for the upper half.
- R13: A reconfiguration done in the order disable, rewrite sense, acknowledge, re-enable leaves no pending flag unless the new code is a level code whose level currently holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NPINS (32) | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (4) | Word address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after bus_rd |
| irq_lo | output | 1 | Interrupt request for the lower pin half |
| irq_hi | output | 1 | Interrupt request for the upper pin half |

## Verification
The assertions assume reset is held for at least one clock edge before anything else happens. They also assume the bus never writes and reads the same address in the same cycle, and that the pins only change while reset is low. The stimulus drives every bus strobe and pin change on the falling clock edge, issues one bus operation at a time, and gives each pin change several cycles to reach the pending flags before the next operation. It always follows the disable, rewrite, acknowledge, re-enable order whenever it changes a sense code on a pin whose detection is already on.

// File: rtl/psi_pkg.sv
package psi_pkg;

  // Word addresses on the register bus
  localparam int ADR_DETEN  = 0;
  localparam int ADR_UNMASK = 1;
  localparam int ADR_MASK   = 2;
  localparam int ADR_RAW    = 3;
  localparam int ADR_STATUS = 4;
  localparam int ADR_ACK    = 5;
  localparam int ADR_SENSE0 = 8;

  localparam int SENSE_W = 4;

  // Low three bits of a sense code; bit 3 is the asynchronous flag
  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_mode_e;

endpackage

// File: rtl/psi_cfg_regs.sv
module psi_cfg_regs
  import psi_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [NPINS-1:0]       det_en,
  output logic [NPINS-1:0]       int_mask,
  output logic [NPINS*SENSE_W-1:0] sense_flat,
  output logic                   sense_hit,
  output logic [DW-1:0]          sense_rd
);

  localparam int FPR   = DW / SENSE_W;
  localparam int NSREG = (NPINS + FPR - 1) / FPR;

  logic [DW-1:0]    sense_q [NSREG];
  logic [NSREG-1:0] sense_sel;
  logic [NPINS-1:0] wbits;

  assign wbits = bus_wdata[NPINS-1:0];

  always_comb begin
    sense_sel = '0;
    for (int r = 0; r < NSREG; r++) begin
      if (bus_addr == AW'(ADR_SENSE0 + r)) sense_sel[r] = 1'b1;
    end
  end

  always_comb begin
    sense_rd = '0;
    for (int r = 0; r < NSREG; r++) begin
      if (sense_sel[r]) sense_rd = sense_q[r];
    end
  end

  assign sense_hit = |sense_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_en   <= '0;
      int_mask <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(ADR_DETEN))  det_en   <= wbits;
      if (bus_addr == AW'(ADR_UNMASK)) int_mask <= int_mask | wbits;
      if (bus_addr == AW'(ADR_MASK))   int_mask <= int_mask & ~wbits;
    end
  end

  for (genvar r = 0; r < NSREG; r++) begin : g_sense_word
    always_ff @(posedge clk) begin
      if (rst)                          sense_q[r] <= '0;
      else if (bus_wr && sense_sel[r])  sense_q[r] <= bus_wdata;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_sense_field
    assign sense_flat[p*SENSE_W +: SENSE_W] = sense_q[p / FPR][(p % FPR)*SENSE_W +: SENSE_W];
  end

endmodule

// File: rtl/psi_detect.sv
module psi_detect
  import psi_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPINS-1:0]         pin_in,
  input  logic [NPINS-1:0]         det_en,
  input  logic [NPINS*SENSE_W-1:0] sense_flat,
  output logic [NPINS-1:0]         hit
);

  // Current and previous samples are tracked whether or not detection is on
  logic [NPINS-1:0] cur_q;
  logic [NPINS-1:0] old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      old_q <= '0;
    end else begin
      cur_q <= pin_in;
      old_q <= cur_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SENSE_W-1:0] code;
    logic               cond;
    assign code = sense_flat[p*SENSE_W +: SENSE_W];

    always_comb begin
      case (code[2:0])
        SNS_RISE: cond = cur_q[p] & ~old_q[p];
        SNS_FALL: cond = ~cur_q[p] & old_q[p];
        SNS_HIGH: cond = cur_q[p];
        SNS_LOW:  cond = ~cur_q[p];
        SNS_BOTH: cond = cur_q[p] ^ old_q[p];
        default:  cond = 1'b0;
      endcase
    end

    assign hit[p] = det_en[p] & cond;
  end

endmodule

// File: rtl/psi_pending.sv
module psi_pending #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] pend
);

  // A new detection wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~ack) | hit;
  end

endmodule

// File: rtl/pin_sense_irq.sv
module pin_sense_irq
  import psi_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_lo,
  output logic             irq_hi
);

  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0]         deten_w;
  logic [NPINS-1:0]         mask_w;
  logic [NPINS*SENSE_W-1:0] sense_w;
  logic                     sense_hit_w;
  logic [DW-1:0]            sense_rd_w;
  logic [NPINS-1:0]         hit_w;
  logic [NPINS-1:0]         ack_w;
  logic [NPINS-1:0]         pend_w;
  logic [NPINS-1:0]         status_w;
  logic [DW-1:0]            rd_mux;

  psi_cfg_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .det_en     (deten_w),
    .int_mask   (mask_w),
    .sense_flat (sense_w),
    .sense_hit  (sense_hit_w),
    .sense_rd   (sense_rd_w)
  );

  psi_detect #(.NPINS(NPINS)) det_i (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .det_en     (deten_w),
    .sense_flat (sense_w),
    .hit        (hit_w)
  );

  assign ack_w = (bus_wr && bus_addr == AW'(ADR_ACK)) ? bus_wdata[NPINS-1:0] : '0;

  psi_pending #(.NPINS(NPINS)) pnd_i (
    .clk  (clk),
    .rst  (rst),
    .hit  (hit_w),
    .ack  (ack_w),
    .pend (pend_w)
  );

  assign status_w = pend_w & mask_w;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(ADR_DETEN))       rd_mux[NPINS-1:0] = deten_w;
    else if (bus_addr == AW'(ADR_UNMASK)) rd_mux[NPINS-1:0] = mask_w;
    else if (bus_addr == AW'(ADR_MASK))   rd_mux[NPINS-1:0] = mask_w;
    else if (bus_addr == AW'(ADR_RAW))    rd_mux[NPINS-1:0] = pend_w;
    else if (bus_addr == AW'(ADR_STATUS)) rd_mux[NPINS-1:0] = status_w;
    else if (sense_hit_w)                 rd_mux = sense_rd_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_lo    <= 1'b0;
      irq_hi    <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_lo <= |status_w[HALF-1:0];
      irq_hi <= |status_w[NPINS-1:HALF];
    end
  end

endmodule

// File: rtl/psi_checker.sv
module psi_checker
  import psi_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] det_en
);

  localparam int HALF = NPINS / 2;

  AST_IRQ_LO_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_lo == (|($past(pend[HALF-1:0] & mask[HALF-1:0]))))); // R12
  AST_IRQ_HI_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_hi == (|($past(pend[NPINS-1:HALF] & mask[NPINS-1:HALF]))))); // R12
  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~det_en) == '0)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADR_ACK)) |=>
      ((pend & $past(bus_wdata[NPINS-1:0]) & ~$past(hit)) == '0)); // R10
  AST_PEND_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R13
  AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADR_UNMASK)) |=>
      ((mask & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R11

endmodule

bind pin_sense_irq psi_checker #(.NPINS(NPINS), .DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .pend      (pend_w),
  .mask      (mask_w),
  .hit       (hit_w),
  .det_en    (deten_w)
);

// File: tb/pin_sense_irq_tb_top.sv
`timescale 1ns/1ps
module pin_sense_irq_tb_top;

  localparam int NP = 32;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;
  exp_t sbq[$];
  logic rd_seen = 1'b0;

  logic [DW-1:0] sh [4];
  logic [DW-1:0] deten_sh = '0;

  always #4 clk = ~clk;

  pin_sense_irq #(.NPINS(NP), .DW(DW), .AW(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pins),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi)
  );

  // Monitor: compares read data with the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (bus_rdata !== e.exp) begin
        errors++;
        $display("FAIL %s: read addr %0d got %h expected %h", e.tag, e.addr, bus_rdata, e.exp);
      end
    end
  end

  task automatic bus_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input int a, input logic [DW-1:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    it.exp = e; it.addr = AW'(a); it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic irq_chk(input logic lo, input logic hi, input string tag);
    @(negedge clk);
    checks++;
    if (irq_lo !== lo || irq_hi !== hi) begin
      errors++;
      $display("FAIL %s: irq lo/hi got %b%b expected %b%b", tag, irq_lo, irq_hi, lo, hi);
    end
  endtask

  task automatic drive_pin(input int p, input logic v);
    @(negedge clk);
    pins[p] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_sense(input int p, input logic [3:0] code);
    sh[p/8][4*(p%8) +: 4] = code;
    bus_write(8 + p/8, sh[p/8]);
  endtask

  task automatic ack(input logic [DW-1:0] m);
    bus_write(5, m);
    repeat (2) @(negedge clk);
  endtask

  task automatic reconf(input int p, input logic [3:0] code);
    deten_sh[p] = 1'b0;
    bus_write(0, deten_sh);
    set_sense(p, code);
    bus_write(5, DW'(1) << p);
    deten_sh[p] = 1'b1;
    bus_write(0, deten_sh);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    read_chk(0, 32'h0, "R1");
    read_chk(1, 32'h0, "R1");
    read_chk(3, 32'h0, "R1");
    read_chk(4, 32'h0, "R1");
    read_chk(8, 32'h0, "R1");
    irq_chk(1'b0, 1'b0, "R1");

    // R2 sense placement
    set_sense(0, 4'h8);
    set_sense(3, 4'hC);
    set_sense(4, 4'h5);
    set_sense(6, 4'hD);
    set_sense(9, 4'hA);
    set_sense(17, 4'h9);
    read_chk(8, 32'h0D05_C008, "R2");
    read_chk(9, 32'h0000_00A0, "R2");
    read_chk(10, 32'h0000_0090, "R2");
    read_chk(5, 32'h0, "R10");

    deten_sh = '1;
    bus_write(0, deten_sh);
    bus_write(1, 32'hFFFF_FFFF);
    read_chk(0, 32'hFFFF_FFFF, "R9");
    read_chk(2, 32'hFFFF_FFFF, "R11");

    // R3 rising
    drive_pin(0, 1'b1);
    read_chk(3, 32'h1, "R3");
    read_chk(4, 32'h1, "R3");
    irq_chk(1'b1, 1'b0, "R3");
    ack(32'h1);
    read_chk(3, 32'h0, "R3");
    drive_pin(0, 1'b0);
    read_chk(3, 32'h0, "R3");

    // R4 falling
    drive_pin(17, 1'b1);
    read_chk(3, 32'h0, "R4");
    drive_pin(17, 1'b0);
    read_chk(3, 32'h0002_0000, "R4");
    ack(32'h0002_0000);
    read_chk(3, 32'h0, "R4");

    // R5 level high
    drive_pin(9, 1'b1);
    read_chk(3, 32'h200, "R5");
    ack(32'h200);
    read_chk(3, 32'h200, "R5");
    drive_pin(9, 1'b0);
    read_chk(3, 32'h200, "R5");
    ack(32'h200);
    read_chk(3, 32'h0, "R5");

    // R6 level low
    reconf(20, 4'h3);
    read_chk(3, 32'h0010_0000, "R6");
    drive_pin(20, 1'b1);
    ack(32'h0010_0000);
    read_chk(3, 32'h0, "R6");

    // R7 both edges
    drive_pin(3, 1'b1);
    read_chk(3, 32'h8, "R7");
    ack(32'h8);
    drive_pin(3, 1'b0);
    read_chk(3, 32'h8, "R7");
    ack(32'h8);
    read_chk(3, 32'h0, "R7");

    // R8 unused codes
    drive_pin(4, 1'b1);
    drive_pin(6, 1'b1);
    read_chk(3, 32'h0, "R8");
    drive_pin(4, 1'b0);
    drive_pin(6, 1'b0);
    read_chk(3, 32'h0, "R8");

    // R9 detection off
    deten_sh[0] = 1'b0;
    bus_write(0, deten_sh);
    drive_pin(0, 1'b1);
    read_chk(3, 32'h0, "R9");
    deten_sh[0] = 1'b1;
    bus_write(0, deten_sh);
    repeat (4) @(negedge clk);
    read_chk(3, 32'h0, "R9");
    drive_pin(0, 1'b0);

    // R10 acknowledge
    drive_pin(0, 1'b1);
    read_chk(3, 32'h1, "R10");
    ack(32'h0);
    read_chk(3, 32'h1, "R10");
    ack(32'h2);
    read_chk(3, 32'h1, "R10");
    ack(32'h1);
    read_chk(3, 32'h0, "R10");

    // R11 mask
    drive_pin(0, 1'b0);
    drive_pin(0, 1'b1);
    bus_write(2, 32'h1);
    repeat (2) @(negedge clk);
    read_chk(1, 32'hFFFF_FFFE, "R11");
    read_chk(3, 32'h1, "R11");
    read_chk(4, 32'h0, "R11");
    irq_chk(1'b0, 1'b0, "R11");
    bus_write(1, 32'h1);
    repeat (2) @(negedge clk);
    read_chk(4, 32'h1, "R11");
    irq_chk(1'b1, 1'b0, "R12");
    ack(32'h1);
    irq_chk(1'b0, 1'b0, "R12");

    // R12 upper half line
    drive_pin(17, 1'b1);
    drive_pin(17, 1'b0);
    read_chk(4, 32'h0002_0000, "R12");
    irq_chk(1'b0, 1'b1, "R12");
    ack(32'h0002_0000);
    irq_chk(1'b0, 1'b0, "R12");

    // R13 reconfiguration without spurious flags
    drive_pin(5, 1'b1);
    read_chk(3, 32'h20, "R13");
    ack(32'h20);
    reconf(5, 4'h9);
    read_chk(3, 32'h0, "R13");
    reconf(5, 4'hC);
    read_chk(3, 32'h0, "R13");
    drive_pin(5, 1'b0);
    read_chk(3, 32'h20, "R13");
    ack(32'h20);
    read_chk(3, 32'h0, "R13");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule